// File: doc/BRIEF.md
# Audio Serial Clock Fault Monitor

This block supervises the two timing lines of an audio serial port, the frame sync and the bit clock, after bringing both into a faster system clock domain. It counts system clocks between frame sync rising edges to find the frame period, and counts bit clock rising edges inside each frame to find the bit-clock ratio. Each measurement is checked against a set of allowed values. A separate watchdog on each line reports a stall when that line stops toggling.

Any fault forces the record-channel gain to the mute code in the same cycle. When all faults have gone, the gain climbs back one code per frame to the level it had when the first fault appeared. After that it follows the live gain setting again. A one-cycle event marks the start of each fault episode, for use by interrupt logic.

Top module: `asi_clk_guard`

## Requirements
- R1: `fault_kind[0]` (rate fault) is set when the frame period is not allowed. The frame period is the number of system clocks between two detected frame sync rising edges. A period is allowed when it lies within TOL cycles of BASE_PERIOD·2^k for some k in 0..N_RATES-1.
- R2: `fault_kind[1]` (ratio fault) is set when the number of bit clock rising edges within one frame is not allowed. A count is allowed when it lies in [MIN_RATIO, MAX_RATIO] and equals either 2^k or 3·2^k.
- R3: The rate and ratio flags are updated only at a frame sync rising edge, and only when the verdict of the frame just closed matches the verdict of the frame before it. One odd frame therefore changes nothing.
- R4: `fault_kind[2]` (stall) is set when either line has shown no transition for `stall_limit` system clocks. It rises limit+4 cycles after the last input transition. It clears at the next transition. The first frame edge after a stall only restarts measurement.
- R5: `fault_active` is the OR of the three `fault_kind` bits. While it is high, `gain_out` is 0 (the mute code) in the same cycle.
- R6: `fault_event` is high for exactly one cycle at each rise of `fault_active`.
- R7: After `fault_active` falls, `gain_out` starts at 0 and rises by one code per frame until it reaches the saved gain. The saved gain is the value of `gain_target` when the fault began from normal operation. One frame later, `gain_out` follows `gain_target` again.
- R8: After reset, `fault_kind` is 0, `fault_active` and `fault_event` are 0, and `gain_out` equals `gain_target`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fsync_in | input | 1 | Frame sync, asynchronous to clk |
| bclk_in | input | 1 | Bit clock, asynchronous to clk |
| stall_limit | input | STALL_W | Stall timeout in system clocks |
| gain_target | input | GW | Gain code applied in normal operation |
| fault_active | output | 1 | Any clock fault present |
| fault_event | output | 1 | One-cycle pulse at fault onset |
| fault_kind | output | 3 | {stall, ratio fault, rate fault} |
| gain_out | output | GW | Record-channel gain code |

## Verification
An input transition reaches the detection logic three system clocks after it is driven: two synchronizer flops plus one edge register. The rate and ratio flags therefore move a few cycles into the frame that follows a frame edge. The bench samples them at the end of frames, so the result of the earlier edge is already settled. It also checks that a single frame with a new verdict leaves the flags unchanged. A stall is expected exactly limit+4 cycles after the last driven transition, and the bench checks a narrow window around that cycle. The ramp is checked by logging every change of `gain_out` with its cycle stamp. Each step must be +1 and must come one frame period after the previous step.

// File: rtl/asi_guard_pkg.sv
package asi_guard_pkg;

    typedef enum logic [1:0] {
        GR_NORMAL = 2'd0,
        GR_MUTED  = 2'd1,
        GR_RAMP   = 2'd2
    } gain_state_e;

    typedef struct packed {
        logic stall;
        logic ratio_bad;
        logic rate_bad;
    } fault_kind_t;

    localparam int unsigned MAX_RATE_SLOTS = 8;

    function automatic logic is_pow2(input int unsigned v);
        return (v != 0) && ((v & (v - 1)) == 0);
    endfunction

    // ratio is allowed when it is 2^k or 3*2^k inside [lo, hi]
    function automatic logic ratio_allowed(input int unsigned r,
                                           input int unsigned lo,
                                           input int unsigned hi);
        if (r < lo || r > hi) return 1'b0;
        if (is_pow2(r)) return 1'b1;
        return ((r % 3) == 0) && is_pow2(r / 3);
    endfunction

    // period is allowed when within tol of base*2^k, k < n
    function automatic logic rate_allowed(input int unsigned p,
                                          input int unsigned base,
                                          input int unsigned n,
                                          input int unsigned tol);
        logic ok;
        ok = 1'b0;
        for (int unsigned k = 0; k < MAX_RATE_SLOTS; k++) begin
            if (k < n) begin
                if ((p + tol >= (base << k)) && (p <= (base << k) + tol))
                    ok = 1'b1;
            end
        end
        return ok;
    endfunction

endpackage

// File: rtl/asi_edge_sync.sv
module asi_edge_sync (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise,
    output logic toggle
);
    logic [2:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[1:0], din};
    end

    assign rise   = sh[1] & ~sh[2];
    assign toggle = sh[1] ^ sh[2];
endmodule

// File: rtl/asi_stall_watch.sv
module asi_stall_watch #(
    parameter int STALL_W = 17
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               toggle,
    input  logic [STALL_W-1:0] limit,
    output logic               stalled
);
    logic [STALL_W-1:0] quiet_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            quiet_cnt <= '0;
            stalled   <= 1'b0;
        end else if (toggle) begin
            quiet_cnt <= '0;
            stalled   <= 1'b0;
        end else if (quiet_cnt < limit) begin
            quiet_cnt <= quiet_cnt + 1'b1;
        end else begin
            stalled   <= 1'b1;
        end
    end
endmodule

// File: rtl/asi_frame_meter.sv
module asi_frame_meter
    import asi_guard_pkg::*;
#(
    parameter int BASE_PERIOD = 64,
    parameter int N_RATES     = 3,
    parameter int TOL         = 2,
    parameter int MIN_RATIO   = 8,
    parameter int MAX_RATIO   = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic fs_rise,
    input  logic bc_rise,
    input  logic restart,
    output logic rate_bad,
    output logic ratio_bad
);
    localparam int PW = $clog2(BASE_PERIOD << N_RATES) + 1;
    localparam int RW = $clog2(MAX_RATIO * 2) + 1;

    logic [PW-1:0] per_cnt;
    logic [RW-1:0] bc_cnt;
    logic [RW-1:0] bc_total;
    logic          primed;
    logic          have_prev;
    logic [1:0]    prev_cls;
    logic [1:0]    cur_cls;

    assign bc_total = (bc_rise && bc_cnt != '1) ? bc_cnt + 1'b1 : bc_cnt;

    always_comb begin
        cur_cls[0] = !rate_allowed(32'(per_cnt), BASE_PERIOD, N_RATES, TOL);
        cur_cls[1] = !ratio_allowed(32'(bc_total), MIN_RATIO, MAX_RATIO);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            per_cnt   <= '0;
            bc_cnt    <= '0;
            primed    <= 1'b0;
            have_prev <= 1'b0;
            prev_cls  <= '0;
            rate_bad  <= 1'b0;
            ratio_bad <= 1'b0;
        end else begin
            if (restart) begin
                primed    <= 1'b0;
                have_prev <= 1'b0;
            end else if (fs_rise) begin
                if (primed) begin
                    if (have_prev && cur_cls == prev_cls) begin
                        rate_bad  <= cur_cls[0];
                        ratio_bad <= cur_cls[1];
                    end
                    prev_cls  <= cur_cls;
                    have_prev <= 1'b1;
                end
                primed <= 1'b1;
            end
            if (fs_rise) begin
                per_cnt <= PW'(1);
                bc_cnt  <= '0;
            end else begin
                per_cnt <= (per_cnt == '1) ? per_cnt : per_cnt + 1'b1;
                bc_cnt  <= bc_total;
            end
        end
    end
endmodule

// File: rtl/asi_gain_ramp.sv
module asi_gain_ramp
    import asi_guard_pkg::*;
#(
    parameter int GW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fault,
    input  logic          tick,
    input  logic [GW-1:0] gain_target,
    output logic [GW-1:0] gain_out,
    output logic          ramping
);
    localparam logic [GW-1:0] MUTE_CODE = '0;

    gain_state_e   state;
    logic [GW-1:0] level;
    logic [GW-1:0] saved;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= GR_NORMAL;
            level <= MUTE_CODE;
            saved <= MUTE_CODE;
        end else if (fault) begin
            if (state == GR_NORMAL) saved <= gain_target;
            state <= GR_MUTED;
            level <= MUTE_CODE;
        end else begin
            case (state)
                GR_MUTED: state <= GR_RAMP;
                GR_RAMP: begin
                    if (tick) begin
                        if (level == saved) state <= GR_NORMAL;
                        else                level <= level + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign gain_out = fault               ? MUTE_CODE   :
                      (state == GR_NORMAL) ? gain_target : level;
    assign ramping  = (state == GR_RAMP);
endmodule

// File: rtl/asi_clk_guard.sv
module asi_clk_guard
    import asi_guard_pkg::*;
#(
    parameter int BASE_PERIOD = 64,
    parameter int N_RATES     = 3,
    parameter int TOL         = 2,
    parameter int MIN_RATIO   = 8,
    parameter int MAX_RATIO   = 64,
    parameter int STALL_W     = 17,
    parameter int GW          = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               fsync_in,
    input  logic               bclk_in,
    input  logic [STALL_W-1:0] stall_limit,
    input  logic [GW-1:0]      gain_target,
    output logic               fault_active,
    output logic               fault_event,
    output logic [2:0]         fault_kind,
    output logic [GW-1:0]      gain_out
);
    localparam int LANES = 2;  // lane 0: bit clock, lane 1: frame sync

    logic [LANES-1:0] raw;
    logic [LANES-1:0] rise;
    logic [LANES-1:0] tog;
    logic [LANES-1:0] stall;
    fault_kind_t      kind;
    logic             fault_prev;
    logic             ramp_on;
    logic             frame_tick;

    assign raw = {fsync_in, bclk_in};

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        asi_edge_sync u_sync (
            .clk    (clk),
            .rst    (rst),
            .din    (raw[i]),
            .rise   (rise[i]),
            .toggle (tog[i])
        );
        asi_stall_watch #(.STALL_W(STALL_W)) u_stall (
            .clk     (clk),
            .rst     (rst),
            .toggle  (tog[i]),
            .limit   (stall_limit),
            .stalled (stall[i])
        );
    end

    assign frame_tick = rise[1];
    assign kind.stall = |stall;

    asi_frame_meter #(
        .BASE_PERIOD (BASE_PERIOD),
        .N_RATES     (N_RATES),
        .TOL         (TOL),
        .MIN_RATIO   (MIN_RATIO),
        .MAX_RATIO   (MAX_RATIO)
    ) u_meter (
        .clk       (clk),
        .rst       (rst),
        .fs_rise   (frame_tick),
        .bc_rise   (rise[0]),
        .restart   (kind.stall),
        .rate_bad  (kind.rate_bad),
        .ratio_bad (kind.ratio_bad)
    );

    assign fault_kind   = kind;
    assign fault_active = |kind;

    always_ff @(posedge clk) begin
        if (rst) fault_prev <= 1'b0;
        else     fault_prev <= fault_active;
    end

    assign fault_event = fault_active & ~fault_prev;

    asi_gain_ramp #(.GW(GW)) u_ramp (
        .clk         (clk),
        .rst         (rst),
        .fault       (fault_active),
        .tick        (frame_tick),
        .gain_target (gain_target),
        .gain_out    (gain_out),
        .ramping     (ramp_on)
    );
endmodule

// File: rtl/asi_clk_guard_chk.sv
module asi_clk_guard_chk #(
    parameter int GW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          fault_active,
    input logic          fault_event,
    input logic [2:0]    fault_kind,
    input logic [GW-1:0] gain_out,
    input logic          ramp_on,
    input logic          frame_tick
);
    // R5: mute whenever a fault is present
    p_mute_on_fault_r5: assert property (@(posedge clk) disable iff (rst)
        fault_active |-> gain_out == '0);

    // R6: onset pulse lasts one cycle
    p_event_single_r6: assert property (@(posedge clk) disable iff (rst)
        fault_event |=> !fault_event);

    // R6: onset pulse coincides with a rise of the fault flag
    p_event_on_rise_r6: assert property (@(posedge clk) disable iff (rst)
        fault_event |-> $rose(fault_active));

    // R3: rate and ratio flags move only after a frame edge
    p_flags_at_frame_r3: assert property (@(posedge clk) disable iff (rst)
        !$stable(fault_kind[1:0]) |-> $past(frame_tick));

    // R7: recovery starts from mute
    p_ramp_from_mute_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(fault_active) |-> gain_out == '0);

    // R7: every change during the ramp is a single step up
    p_ramp_step_r7: assert property (@(posedge clk) disable iff (rst)
        (ramp_on && $past(ramp_on) && !fault_active && gain_out != $past(gain_out))
            |-> gain_out == $past(gain_out) + 1'b1);
endmodule

bind asi_clk_guard asi_clk_guard_chk #(.GW(GW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .fault_active (fault_active),
    .fault_event  (fault_event),
    .fault_kind   (fault_kind),
    .gain_out     (gain_out),
    .ramp_on      (ramp_on),
    .frame_tick   (frame_tick)
);

// File: tb/asi_clk_guard_tb_top.sv
`timescale 1ns/1ps
module asi_clk_guard_tb_top;
    localparam int GW = 8, SW = 17, BASE = 64, NR = 3, TOL = 2;
    localparam int RMIN = 8, RMAX = 64, LIMIT = 600;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst;
    logic          fsync_in, bclk_in;
    logic [SW-1:0] stall_limit;
    logic [GW-1:0] gain_target;
    logic          fault_active, fault_event;
    logic [2:0]    fault_kind;
    logic [GW-1:0] gain_out;

    asi_clk_guard #(
        .BASE_PERIOD(BASE), .N_RATES(NR), .TOL(TOL),
        .MIN_RATIO(RMIN), .MAX_RATIO(RMAX), .STALL_W(SW), .GW(GW)
    ) dut_i (
        .clk(clk), .rst(rst), .fsync_in(fsync_in), .bclk_in(bclk_in),
        .stall_limit(stall_limit), .gain_target(gain_target),
        .fault_active(fault_active), .fault_event(fault_event),
        .fault_kind(fault_kind), .gain_out(gain_out)
    );

    int checks = 0, errors = 0, cyc = 0;
    int last_bc = 0, last_fs = 0;
    int ev_cnt = 0;
    int stall_at = 0;
    logic stall_arm = 1'b0;
    logic log_en = 1'b0;
    int log_v[16], log_t[16];
    int log_n = 0, last_g = 0;
    logic reported = 1'b0;

    always @(posedge clk) cyc++;

    always @(negedge clk) begin
        if (fault_event) ev_cnt++;
        if (stall_arm && fault_kind[2]) begin
            stall_at  = cyc;
            stall_arm = 1'b0;
        end
        if (log_en && int'(gain_out) != last_g && log_n < 16) begin
            log_v[log_n] = int'(gain_out);
            log_t[log_n] = cyc;
            log_n++;
        end
        last_g = int'(gain_out);
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_rng(input string req, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    function automatic int rate_bad_exp(input int p);
        for (int k = 0; k < NR; k++) begin
            int d;
            d = p - BASE * (2 ** k);
            if (d <= TOL && d >= -TOL) return 0;
        end
        return 1;
    endfunction

    function automatic int ratio_bad_exp(input int r);
        for (int k = 0; k < 8; k++) begin
            int a, b;
            a = 2 ** k;
            b = 3 * (2 ** k);
            if (a >= RMIN && a <= RMAX && a == r) return 0;
            if (b >= RMIN && b <= RMAX && b == r) return 0;
        end
        return 1;
    endfunction

    // frame of 2*h*r clocks: fsync high for the first half, r bit clock rises
    task automatic run_frames(input int h, input int r, input int n,
                              input bit bc_off, input bit fs_off);
        for (int f = 0; f < n; f++) begin
            for (int c = 0; c < 2 * h * r; c++) begin
                logic nf, nb;
                @(negedge clk);
                nf = fs_off ? 1'b0 : (c < h * r);
                nb = bc_off ? 1'b0 : (((c / h) % 2) == 1);
                if (nb != bclk_in)  last_bc = cyc;
                if (nf != fsync_in) last_fs = cyc;
                fsync_in = nf;
                bclk_in  = nb;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        report();
    end

    initial begin
        rst = 1'b1; fsync_in = 1'b0; bclk_in = 1'b0;
        stall_limit = SW'(LIMIT); gain_target = 8'd6;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8: reset state
        chk("R8 kind", int'(fault_kind), 0);
        chk("R8 active", int'(fault_active), 0);
        chk("R8 event", int'(fault_event), 0);
        chk("R8 gain", int'(gain_out), 6);

        // good traffic: 64-cycle frames, 16 bit clocks
        run_frames(2, 16, 6, 0, 0);
        chk("R5 no fault on good clocks", int'(fault_active), 0);
        chk("R8 gain follows target", int'(gain_out), 6);

        // R3: one bad frame alone changes nothing (80 cycles, 20 bit clocks)
        run_frames(2, 20, 2, 0, 0);
        chk("R3 single bad frame ignored", int'(fault_active), 0);
        run_frames(2, 20, 1, 0, 0);
        chk("R3 second bad frame sets flags", int'(fault_kind), 3);
        chk("R5 mute during fault", int'(gain_out), 0);
        chk("R6 one event at onset", ev_cnt, 1);
        run_frames(2, 20, 2, 0, 0);
        chk("R6 no further events", ev_cnt, 1);

        // R7: ramp back to the saved gain 6, then follow new target 9
        gain_target = 8'd9;
        log_n = 0; log_en = 1'b1;
        run_frames(2, 16, 12, 0, 0);
        log_en = 1'b0;
        chk("R7 step count", log_n, 7);
        for (int i = 0; i < 6; i++) chk("R7 step value", log_v[i], i + 1);
        chk("R7 final follows target", log_v[6], 9);
        for (int i = 1; i < 7; i++) chk("R7 step spacing", log_t[i] - log_t[i-1], 64);
        chk("R6 events after ramp", ev_cnt, 1);

        // R4: bit clock stall
        gain_target = 8'd3;
        run_frames(2, 16, 2, 0, 0);
        stall_arm = 1'b1; stall_at = 0;
        run_frames(2, 16, 12, 1, 0);
        chk_rng("R4 bit clock stall latency", stall_at - last_bc, LIMIT + 2, LIMIT + 6);
        chk("R4 stall bit", int'(fault_kind[2]), 1);
        chk("R5 mute on stall", int'(gain_out), 0);
        run_frames(2, 16, 6, 0, 0);
        chk("R4 recovery after bit clock stall", int'(fault_kind), 0);

        // R4: frame sync stall
        stall_arm = 1'b1; stall_at = 0;
        run_frames(2, 16, 12, 0, 1);
        chk_rng("R4 frame sync stall latency", stall_at - last_fs, LIMIT + 2, LIMIT + 6);
        chk("R4 stall bit fsync", int'(fault_kind[2]), 1);
        run_frames(2, 16, 6, 0, 0);
        chk("R4 recovery after frame sync stall", int'(fault_kind), 0);

        // R1/R2 sweep over bit clock half period and ratio
        for (int h = 1; h <= 4; h++) begin
            for (int r = 3; r <= 40; r++) begin
                int eb_rate, eb_ratio;
                eb_rate  = rate_bad_exp(2 * h * r);
                eb_ratio = ratio_bad_exp(r);
                run_frames(h, r, 4, 0, 0);
                chk("R1 rate flag", int'(fault_kind[0]), eb_rate);
                chk("R2 ratio flag", int'(fault_kind[1]), eb_ratio);
                if (eb_rate != 0 || eb_ratio != 0)
                    chk("R5 mute in sweep", int'(gain_out), 0);
            end
        end

        report();
    end
endmodule